// File: doc/BRIEF.md
# Dual-Source Bus Trace Capture

This block records bus activity from two masters, a main CPU and a coprocessor, into a 64-line circular trace store. Each stored line carries one address slot per master plus an 8-bit information byte. What triggers a write and what lands in each slot depends on one of four capture modes.

- **Normal** and **Loop1** keep change-of-flow addresses.
- **Pure PC** keeps opcode-fetch program counters.
- **Detail** keeps every real access of one traced master. The other master's slot holds a program-counter snapshot.

Capture runs while the arm input is high. Rearming restarts the store from line 0. Once capture is disarmed, a debugger reads lines back through a small read port with one cycle of latency.

Top module: `trace_capture`

## Requirements
- R1: After reset, `wr_ptr_o` is 0, `wrapped_o` is 0 and `rd_valid_o` is 0.
- R2: While `arm_i` is low, no line is written and `wr_ptr_o` holds. On the first cycle `arm_i` is high after being low, the pointer and `wrapped_o` restart from 0, so that cycle's write goes to line 0.
- R3: Modes use the encoding `mode_i` 0 = Normal, 1 = Loop1, 2 = Pure PC, 3 = Detail. Source selection is `src_i` bit 0 = CPU, bit 1 = coprocessor. In Normal mode, a line is written only when a traced master flags a change-of-flow. Info bit 7 is the CPU destination flag (1 = destination). Bit 6 is the CPU vector flag. Bit 7 is forced to 1 whenever bit 6 is 1. All other info bits are 0.
- R4: In Normal, Loop1 and Pure PC modes with both sources traced, info bit 4 is 1 when the CPU slot holds a valid entry and 0 otherwise. A slot without an event for its master holds 0. With a single source, bit 4 is 0. Simultaneous events from both masters share one line.
- R5: In Loop1 mode, a CPU change-of-flow whose address equals the last CPU address stored since arming is dropped.
- R6: In Pure PC mode, a line is written for each opcode fetch of a traced master. The slot holds that master's program counter. Info bits 7 and 6 are 0.
- R7: In Detail mode tracing the CPU (`src_i` bit 0 set), each CPU cycle that is neither an opcode fetch nor a free cycle writes one line.
  - The CPU slot holds the CPU address and the coprocessor slot holds the coprocessor program counter.
  - Info bit 6 is the CPU size flag, bit 5 the CPU read/write flag, bit 3 the coprocessor acknowledge (0 = free cycle) and bit 0 the coprocessor opcode-fetch flag.
- R8: In Detail mode tracing only the coprocessor (`src_i` = 2), each acknowledged, non-opcode-fetch coprocessor cycle writes one line.
  - The coprocessor slot holds its address and the CPU slot holds the CPU program counter.
  - Info bit 7 is 0 when the CPU cycle was free and 1 otherwise. Bit 4 is the CPU opcode-fetch flag. Bit 2 is the coprocessor size flag and bit 1 its read/write flag.
- R9: In Detail mode, an opcode-fetch or free cycle on the traced master writes nothing, even when the other master makes a real access in that cycle.
- R10: The write pointer wraps from 63 to 0. `wrapped_o` sets when line 63 is written and stays set until the next arming.
- R11: A read request (`rd_en_i`) while disarmed returns line `rd_addr_i` on `rd_cpu_o`/`rd_cop_o`/`rd_info_o` with `rd_valid_o` high one cycle later. While armed, `rd_valid_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arm_i | input | 1 | Capture enable; a rising level restarts the store |
| mode_i | input | 2 | Capture mode (0 Normal, 1 Loop1, 2 Pure PC, 3 Detail) |
| src_i | input | 2 | Traced masters: bit 0 CPU, bit 1 coprocessor |
| cpu_addr_i | input | 16 | CPU access or change-of-flow address |
| cpu_pc_i | input | 16 | CPU program counter |
| cpu_sz_i | input | 1 | CPU access size flag |
| cpu_rw_i | input | 1 | CPU read/write flag |
| cpu_opf_i | input | 1 | CPU opcode-fetch cycle |
| cpu_free_i | input | 1 | CPU free cycle (1 = free) |
| cpu_cof_i | input | 1 | CPU change-of-flow event this cycle |
| cpu_dst_i | input | 1 | CPU event address is a destination |
| cpu_vec_i | input | 1 | CPU event address is a vector |
| cop_addr_i | input | 16 | Coprocessor access or change-of-flow address |
| cop_pc_i | input | 16 | Coprocessor program counter |
| cop_sz_i | input | 1 | Coprocessor access size flag |
| cop_rw_i | input | 1 | Coprocessor read/write flag |
| cop_opf_i | input | 1 | Coprocessor opcode-fetch cycle |
| cop_ack_i | input | 1 | Coprocessor bus acknowledge (0 = free cycle) |
| cop_cof_i | input | 1 | Coprocessor change-of-flow event this cycle |
| rd_en_i | input | 1 | Read request |
| rd_addr_i | input | 6 | Line to read |
| rd_valid_o | output | 1 | Read data valid |
| rd_cpu_o | output | 16 | CPU slot of the read line |
| rd_cop_o | output | 16 | Coprocessor slot of the read line |
| rd_info_o | output | 8 | Information byte of the read line |
| wr_ptr_o | output | 6 | Next line to be written |
| wrapped_o | output | 1 | Store has wrapped since arming |

## Verification
Two collisions matter most.

- **Both sources in one cycle.** With both sources traced, the CPU and coprocessor can both raise an event in the same cycle. The bench drives events on both masters together and judges that a single line carries both slots with info bit 4 set. It also drives a coprocessor-only event and expects a line whose CPU slot is 0 and whose bit 4 is clear.
- **Traced master skips while the other is busy.** In Detail mode, the traced master's opcode-fetch or free cycle can coincide with a real access by the other master. The bench stacks these together and judges by the pointer value and the lines read back that no line was written.

// File: rtl/trace_pkg.sv
package trace_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL  = 2'd0,
    MODE_LOOP1   = 2'd1,
    MODE_PURE_PC = 2'd2,
    MODE_DETAIL  = 2'd3
  } trace_mode_e;

  localparam int unsigned INFO_W = 8;

  // info byte bit positions
  localparam int unsigned B_CPU_DST  = 7;
  localparam int unsigned B_CPU_NFREE = 7;
  localparam int unsigned B_CPU_VEC  = 6;
  localparam int unsigned B_CPU_SZ   = 6;
  localparam int unsigned B_CPU_RW   = 5;
  localparam int unsigned B_CPU_VLD  = 4;
  localparam int unsigned B_CPU_OPF  = 4;
  localparam int unsigned B_COP_ACK  = 3;
  localparam int unsigned B_COP_SZ   = 2;
  localparam int unsigned B_COP_RW   = 1;
  localparam int unsigned B_COP_OPF  = 0;
endpackage

// File: rtl/trace_encode.sv
module trace_encode
  import trace_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic              start_i,
  input  logic [1:0]        mode_i,
  input  logic [1:0]        src_i,
  input  logic [AW-1:0]     cpu_addr_i,
  input  logic [AW-1:0]     cpu_pc_i,
  input  logic              cpu_sz_i,
  input  logic              cpu_rw_i,
  input  logic              cpu_opf_i,
  input  logic              cpu_free_i,
  input  logic              cpu_cof_i,
  input  logic              cpu_dst_i,
  input  logic              cpu_vec_i,
  input  logic [AW-1:0]     cop_addr_i,
  input  logic [AW-1:0]     cop_pc_i,
  input  logic              cop_sz_i,
  input  logic              cop_rw_i,
  input  logic              cop_opf_i,
  input  logic              cop_ack_i,
  input  logic              cop_cof_i,
  output logic              we_o,
  output logic [AW-1:0]     line_cpu_o,
  output logic [AW-1:0]     line_cop_o,
  output logic [INFO_W-1:0] line_info_o
);
  trace_mode_e   mode;
  logic          both, trc_cpu, trc_cop;
  logic          cpu_ev, cop_ev, loop_hit;
  logic [AW-1:0] last_addr_q;
  logic          last_vld_q;

  assign mode    = trace_mode_e'(mode_i);
  assign trc_cpu = src_i[0];
  assign trc_cop = src_i[1];
  assign both    = trc_cpu & trc_cop;

  // Loop1: repeat of last stored CPU address is dropped
  assign loop_hit = (mode == MODE_LOOP1) && last_vld_q && !start_i &&
                    (cpu_addr_i == last_addr_q);

  always_comb begin
    cpu_ev      = 1'b0;
    cop_ev      = 1'b0;
    we_o        = 1'b0;
    line_cpu_o  = '0;
    line_cop_o  = '0;
    line_info_o = '0;
    case (mode)
      MODE_NORMAL, MODE_LOOP1: begin
        cpu_ev = trc_cpu & cpu_cof_i & ~loop_hit;
        cop_ev = trc_cop & cop_cof_i;
        we_o   = cpu_ev | cop_ev;
        line_cpu_o = cpu_ev ? cpu_addr_i : '0;
        line_cop_o = cop_ev ? cop_addr_i : '0;
        line_info_o[B_CPU_DST] = cpu_ev & (cpu_dst_i | cpu_vec_i);
        line_info_o[B_CPU_VEC] = cpu_ev & cpu_vec_i;
        line_info_o[B_CPU_VLD] = both & cpu_ev;
      end
      MODE_PURE_PC: begin
        cpu_ev = trc_cpu & cpu_opf_i;
        cop_ev = trc_cop & cop_opf_i;
        we_o   = cpu_ev | cop_ev;
        line_cpu_o = cpu_ev ? cpu_pc_i : '0;
        line_cop_o = cop_ev ? cop_pc_i : '0;
        line_info_o[B_CPU_VLD] = both & cpu_ev;
      end
      MODE_DETAIL: begin
        if (trc_cpu) begin
          we_o       = ~cpu_opf_i & ~cpu_free_i;
          line_cpu_o = cpu_addr_i;
          line_cop_o = cop_pc_i;
          line_info_o[B_CPU_SZ]  = cpu_sz_i;
          line_info_o[B_CPU_RW]  = cpu_rw_i;
          line_info_o[B_COP_ACK] = cop_ack_i;
          line_info_o[B_COP_OPF] = cop_opf_i;
        end else if (trc_cop) begin
          we_o       = ~cop_opf_i & cop_ack_i;
          line_cpu_o = cpu_pc_i;
          line_cop_o = cop_addr_i;
          line_info_o[B_CPU_NFREE] = ~cpu_free_i;
          line_info_o[B_CPU_OPF]   = cpu_opf_i;
          line_info_o[B_COP_SZ]    = cop_sz_i;
          line_info_o[B_COP_RW]    = cop_rw_i;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_addr_q <= '0;
      last_vld_q  <= 1'b0;
    end else if (arm_i && cpu_ev && mode == MODE_LOOP1) begin
      last_addr_q <= cpu_addr_i;
      last_vld_q  <= 1'b1;
    end else if (start_i) begin
      last_vld_q  <= 1'b0;
    end
  end

  // R5: a stored Loop1 CPU address is not stored again on the next identical event
  a_r5_loop_repeat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_i && mode == MODE_LOOP1 && src_i == 2'b01 && cpu_cof_i && we_o)
    |=> !(cpu_cof_i && arm_i && !start_i && mode == MODE_LOOP1 &&
          src_i == 2'b01 && cpu_addr_i == $past(cpu_addr_i) && we_o));
endmodule

// File: rtl/trace_store.sv
module trace_store #(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned LINE_W = 40,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic              start_i,
  input  logic              we_i,
  input  logic [LINE_W-1:0] wdata_i,
  input  logic              rd_en_i,
  input  logic [PTR_W-1:0]  rd_addr_i,
  output logic              rd_valid_o,
  output logic [LINE_W-1:0] rd_data_o,
  output logic [PTR_W-1:0]  ptr_o,
  output logic              wrapped_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [LINE_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  ptr_q, base;
  logic              wrap_q, wr;

  assign base = start_i ? '0 : ptr_q;
  assign wr   = arm_i & we_i;

  always_ff @(posedge clk_i) begin
    if (wr) mem[base] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      wrap_q <= 1'b0;
    end else begin
      if (wr)           ptr_q <= (base == LAST) ? '0 : base + PTR_W'(1);
      else if (start_i) ptr_q <= '0;
      if (wr && base == LAST) wrap_q <= 1'b1;
      else if (start_i)       wrap_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= rd_en_i & ~arm_i;
      if (rd_en_i && !arm_i) rd_data_o <= mem[rd_addr_i];
    end
  end

  assign ptr_o     = ptr_q;
  assign wrapped_o = wrap_q;

  a_r2_hold_disarmed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_i |=> $stable(ptr_q));
  a_r2_no_write_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_i && !start_i && !we_i) |=> $stable(ptr_q));
  a_r10_ptr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_i && !start_i && we_i && ptr_q != LAST) |=> ptr_q == $past(ptr_q) + PTR_W'(1));
  a_r10_wrap_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_q && !start_i) |=> wrap_q);
  a_r11_no_read_armed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> !rd_valid_o);
endmodule

// File: rtl/trace_capture.sv
module trace_capture
  import trace_pkg::*;
#(
  parameter int unsigned AW    = 16,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned PTR_W  = $clog2(DEPTH),
  localparam int unsigned LINE_W = 2 * AW + INFO_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic [1:0]        mode_i,
  input  logic [1:0]        src_i,
  input  logic [AW-1:0]     cpu_addr_i,
  input  logic [AW-1:0]     cpu_pc_i,
  input  logic              cpu_sz_i,
  input  logic              cpu_rw_i,
  input  logic              cpu_opf_i,
  input  logic              cpu_free_i,
  input  logic              cpu_cof_i,
  input  logic              cpu_dst_i,
  input  logic              cpu_vec_i,
  input  logic [AW-1:0]     cop_addr_i,
  input  logic [AW-1:0]     cop_pc_i,
  input  logic              cop_sz_i,
  input  logic              cop_rw_i,
  input  logic              cop_opf_i,
  input  logic              cop_ack_i,
  input  logic              cop_cof_i,
  input  logic              rd_en_i,
  input  logic [PTR_W-1:0]  rd_addr_i,
  output logic              rd_valid_o,
  output logic [AW-1:0]     rd_cpu_o,
  output logic [AW-1:0]     rd_cop_o,
  output logic [INFO_W-1:0] rd_info_o,
  output logic [PTR_W-1:0]  wr_ptr_o,
  output logic              wrapped_o
);
  logic              arm_q, start;
  logic              we;
  logic [AW-1:0]     l_cpu, l_cop;
  logic [INFO_W-1:0] l_info;
  logic [LINE_W-1:0] rd_line;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) arm_q <= 1'b0;
    else         arm_q <= arm_i;
  end
  assign start = arm_i & ~arm_q;

  trace_encode #(.AW(AW)) u_enc (
    .clk_i, .rst_ni, .arm_i, .start_i(start), .mode_i, .src_i,
    .cpu_addr_i, .cpu_pc_i, .cpu_sz_i, .cpu_rw_i, .cpu_opf_i, .cpu_free_i,
    .cpu_cof_i, .cpu_dst_i, .cpu_vec_i,
    .cop_addr_i, .cop_pc_i, .cop_sz_i, .cop_rw_i, .cop_opf_i, .cop_ack_i,
    .cop_cof_i,
    .we_o(we), .line_cpu_o(l_cpu), .line_cop_o(l_cop), .line_info_o(l_info)
  );

  trace_store #(.DEPTH(DEPTH), .LINE_W(LINE_W)) u_store (
    .clk_i, .rst_ni, .arm_i, .start_i(start), .we_i(we),
    .wdata_i({l_cpu, l_cop, l_info}),
    .rd_en_i, .rd_addr_i, .rd_valid_o, .rd_data_o(rd_line),
    .ptr_o(wr_ptr_o), .wrapped_o
  );

  assign {rd_cpu_o, rd_cop_o, rd_info_o} = rd_line;

  // R9: traced CPU skip cycle in Detail mode leaves the pointer alone
  a_r9_detail_skip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_i && !start && mode_i == MODE_DETAIL && src_i[0] && (cpu_opf_i || cpu_free_i))
    |=> $stable(wr_ptr_o));
  // R2: a fresh arming with no write leaves the pointer at 0
  a_r2_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && !we) |=> (wr_ptr_o == '0 && !wrapped_o));
endmodule

// File: tb/sim_trace_capture.sv
module sim_trace_capture;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        arm_i = 1'b0;
  logic [1:0]  mode_i = '0, src_i = '0;
  logic [15:0] cpu_addr_i, cpu_pc_i, cop_addr_i, cop_pc_i;
  logic        cpu_sz_i, cpu_rw_i, cpu_opf_i, cpu_free_i, cpu_cof_i, cpu_dst_i, cpu_vec_i;
  logic        cop_sz_i, cop_rw_i, cop_opf_i, cop_ack_i, cop_cof_i;
  logic        rd_en_i = 1'b0;
  logic [5:0]  rd_addr_i = '0;
  logic        rd_valid_o, wrapped_o;
  logic [15:0] rd_cpu_o, rd_cop_o;
  logic [7:0]  rd_info_o;
  logic [5:0]  wr_ptr_o;

  int checks = 0, errors = 0;
  int n_exp = 0;
  logic [15:0] exp_cpu [64];
  logic [15:0] exp_cop [64];
  logic [7:0]  exp_info [64];

  always #5 clk = ~clk;

  trace_capture u0 (
    .clk_i(clk), .rst_ni, .arm_i, .mode_i, .src_i,
    .cpu_addr_i, .cpu_pc_i, .cpu_sz_i, .cpu_rw_i, .cpu_opf_i, .cpu_free_i,
    .cpu_cof_i, .cpu_dst_i, .cpu_vec_i,
    .cop_addr_i, .cop_pc_i, .cop_sz_i, .cop_rw_i, .cop_opf_i, .cop_ack_i,
    .cop_cof_i, .rd_en_i, .rd_addr_i, .rd_valid_o, .rd_cpu_o, .rd_cop_o,
    .rd_info_o, .wr_ptr_o, .wrapped_o
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic clr_in();
    cpu_addr_i = '0; cpu_pc_i = '0; cop_addr_i = '0; cop_pc_i = '0;
    cpu_sz_i = 0; cpu_rw_i = 0; cpu_opf_i = 0; cpu_free_i = 0;
    cpu_cof_i = 0; cpu_dst_i = 0; cpu_vec_i = 0;
    cop_sz_i = 0; cop_rw_i = 0; cop_opf_i = 0; cop_ack_i = 0; cop_cof_i = 0;
  endtask

  task automatic push(input logic [15:0] c, input logic [15:0] p, input logic [7:0] i);
    exp_cpu[n_exp] = c; exp_cop[n_exp] = p; exp_info[n_exp] = i;
    n_exp++;
  endtask

  task automatic begin_cap(input logic [1:0] m, input logic [1:0] s);
    arm_i = 1'b1; mode_i = m; src_i = s; n_exp = 0; clr_in();
  endtask

  task automatic end_cap();
    clr_in(); arm_i = 1'b0; step();
  endtask

  task automatic verify(input string req, input int n, input int exp_ptr);
    chk(wr_ptr_o == 6'(exp_ptr), {req, " ptr"}, 64'(wr_ptr_o), 64'(exp_ptr));
    for (int i = 0; i < n; i++) begin
      rd_en_i = 1'b1; rd_addr_i = 6'(i);
      step();
      chk(rd_valid_o, {req, " rd_valid"}, 64'(rd_valid_o), 64'd1);
      chk({rd_cpu_o, rd_cop_o, rd_info_o} == {exp_cpu[i], exp_cop[i], exp_info[i]},
          {req, " line"}, 64'({rd_cpu_o, rd_cop_o, rd_info_o}),
          64'({exp_cpu[i], exp_cop[i], exp_info[i]}));
    end
    rd_en_i = 1'b0;
    step();
  endtask

  task automatic t_reset();
    chk(wr_ptr_o == 0, "R1 ptr", 64'(wr_ptr_o), 0);
    chk(!wrapped_o, "R1 wrapped", 64'(wrapped_o), 0);
    chk(!rd_valid_o, "R1 rd_valid", 64'(rd_valid_o), 0);
  endtask

  task automatic t_normal();  // R3
    begin_cap(2'd0, 2'b01);
    cpu_cof_i = 1; cpu_addr_i = 16'h1000; step(); push(16'h1000, 0, 8'h00);
    clr_in(); cpu_addr_i = 16'h2000; step();
    cpu_cof_i = 1; cpu_dst_i = 1; cpu_addr_i = 16'h1100; step(); push(16'h1100, 0, 8'h80);
    clr_in(); cpu_cof_i = 1; cpu_vec_i = 1; cpu_addr_i = 16'h1200; step(); push(16'h1200, 0, 8'hC0);
    end_cap();
    verify("R3", n_exp, 3);
    // R2: disarmed events ignored
    cpu_cof_i = 1; cpu_addr_i = 16'h3000;
    repeat (3) step();
    clr_in();
    chk(wr_ptr_o == 3, "R2 disarmed ptr", 64'(wr_ptr_o), 3);
    verify("R2 disarmed lines", n_exp, 3);
  endtask

  task automatic t_both();  // R4
    begin_cap(2'd0, 2'b11);
    cpu_cof_i = 1; cpu_dst_i = 1; cpu_addr_i = 16'h0010; step(); push(16'h0010, 0, 8'h90);
    clr_in(); cop_cof_i = 1; cop_addr_i = 16'h0020; step(); push(0, 16'h0020, 8'h00);
    clr_in(); cpu_cof_i = 1; cpu_addr_i = 16'h0030; cop_cof_i = 1; cop_addr_i = 16'h0040;
    step(); push(16'h0030, 16'h0040, 8'h10);
    end_cap();
    verify("R4", n_exp, 3);
  endtask

  task automatic t_loop1();  // R5
    begin_cap(2'd1, 2'b01);
    cpu_cof_i = 1; cpu_dst_i = 1;
    cpu_addr_i = 16'h0050; step(); push(16'h0050, 0, 8'h80);
    cpu_addr_i = 16'h0050; step();
    cpu_addr_i = 16'h0060; step(); push(16'h0060, 0, 8'h80);
    cpu_addr_i = 16'h0050; step(); push(16'h0050, 0, 8'h80);
    end_cap();
    verify("R5", n_exp, 3);
  endtask

  task automatic t_purepc();  // R6
    begin_cap(2'd2, 2'b11);
    cpu_opf_i = 1; cpu_pc_i = 16'h0100; cpu_dst_i = 1; cpu_vec_i = 1; cpu_cof_i = 1;
    step(); push(16'h0100, 0, 8'h10);
    clr_in(); cop_opf_i = 1; cop_pc_i = 16'h0200; step(); push(0, 16'h0200, 8'h00);
    clr_in(); cpu_cof_i = 1; cop_cof_i = 1; step();
    clr_in(); cpu_opf_i = 1; cpu_pc_i = 16'h0110; cop_opf_i = 1; cop_pc_i = 16'h0210;
    step(); push(16'h0110, 16'h0210, 8'h10);
    end_cap();
    verify("R6", n_exp, 3);
  endtask

  task automatic t_detail_cpu();  // R7, R9
    begin_cap(2'd3, 2'b01);
    cpu_addr_i = 16'h0300; cpu_sz_i = 1; cpu_rw_i = 1; cop_pc_i = 16'h0700; cop_ack_i = 1;
    step(); push(16'h0300, 16'h0700, 8'h68);
    clr_in(); cpu_opf_i = 1; cop_ack_i = 1; cop_addr_i = 16'h0777; step();
    clr_in(); cpu_free_i = 1; cop_ack_i = 1; step();
    chk(wr_ptr_o == 1, "R9 cpu skip ptr", 64'(wr_ptr_o), 1);
    clr_in(); cpu_addr_i = 16'h0304; cop_pc_i = 16'h0704; cop_opf_i = 1;
    step(); push(16'h0304, 16'h0704, 8'h01);
    end_cap();
    verify("R7", n_exp, 2);
  endtask

  task automatic t_detail_cop();  // R8, R9
    begin_cap(2'd3, 2'b10);
    cop_addr_i = 16'h0400; cop_sz_i = 1; cop_ack_i = 1; cpu_pc_i = 16'h0800; cpu_opf_i = 1;
    step(); push(16'h0800, 16'h0400, 8'h94);
    clr_in(); cop_ack_i = 0; cpu_addr_i = 16'h0999; step();
    clr_in(); cop_ack_i = 1; cop_opf_i = 1; step();
    chk(wr_ptr_o == 1, "R9 cop skip ptr", 64'(wr_ptr_o), 1);
    clr_in(); cop_addr_i = 16'h0402; cop_rw_i = 1; cop_ack_i = 1; cpu_pc_i = 16'h0802; cpu_free_i = 1;
    step(); push(16'h0802, 16'h0402, 8'h02);
    end_cap();
    verify("R8", n_exp, 2);
  endtask

  task automatic t_wrap();  // R10, R2
    begin_cap(2'd0, 2'b01);
    for (int k = 0; k < 70; k++) begin
      cpu_cof_i = 1; cpu_addr_i = 16'h1000 + 16'(k);
      step();
    end
    end_cap();
    chk(wrapped_o, "R10 wrapped", 64'(wrapped_o), 1);
    for (int j = 0; j < 64; j++) begin
      exp_cpu[j] = 16'h1000 + 16'((j < 6) ? 64 + j : j);
      exp_cop[j] = '0; exp_info[j] = '0;
    end
    verify("R10", 64, 6);
    arm_i = 1'b1; step();
    chk(wr_ptr_o == 0, "R2 rearm ptr", 64'(wr_ptr_o), 0);
    chk(!wrapped_o, "R2 rearm wrapped", 64'(wrapped_o), 0);
    end_cap();
  endtask

  task automatic t_read_armed();  // R11
    begin_cap(2'd0, 2'b01);
    rd_en_i = 1'b1; rd_addr_i = '0;
    step();
    chk(!rd_valid_o, "R11 armed read", 64'(rd_valid_o), 0);
    step();
    chk(!rd_valid_o, "R11 armed read 2", 64'(rd_valid_o), 0);
    rd_en_i = 1'b0;
    end_cap();
  endtask

  bit done = 0;

  initial begin
    clr_in();
    repeat (3) step();
    t_reset();
    rst_ni = 1'b1;
    step();
    t_reset();
    t_normal();
    t_both();
    t_loop1();
    t_purepc();
    t_detail_cpu();
    t_detail_cop();
    t_wrap();
    t_read_armed();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #1500000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule